// File: doc/BRIEF.md
# UART Modem Control Register Bank

This block is a register-file slice of a UART controller. It holds the modem control byte and an enhanced-feature enable bit. It also holds the storage for a scratchpad, a trigger control byte and a trigger level byte, and it builds the modem status byte. A host reaches all of these through a small synchronous register bus, with byte writes on a strobe and registered byte reads on a strobe.

Two offsets are banked. When the enhanced-feature bit is set and the bank-select bit of the control byte is also set, the offset that normally shows modem status shows the trigger control byte instead. In the same state, the scratchpad offset shows the trigger level byte. The Xon-Any and IR-mode bits of the control byte can only be written while the enhanced-feature bit is set. The control byte drives these outputs: the interrupt output enable and the complementary general-purpose output, the loopback control, the IR-mode control and the Xon-Any enable. It also supplies the ring-indicator value used in loopback.

Top module: `uart_mcr_bank`

## Requirements
- R1: After rst_ni is released, the control byte, the feature bit, the trigger control, trigger level and scratchpad bytes all read 0x00. In this state irq_oe_o, loopback_o, xon_any_o, ir_mode_o and lb_ri_o are 0, and gpo_n_o is 1.
- R2: Offset 6 selects the trigger control byte and offset 7 selects the trigger level byte when the feature bit is 1 and control bit 2 is 1. In every other case, offset 6 selects modem status and offset 7 selects the scratchpad, whatever control bit 2 holds.
- R3: Modem status is read-only. A write to offset 6 while modem status is selected changes neither the trigger control byte nor any other register.
- R4: The trigger control, trigger level and scratchpad bytes are separate read/write storage. Each one is written only through its own offset while it is selected.
- R5: Control bit 3 drives irq_oe_o directly and drives gpo_n_o inverted. irq_o equals irq_i while bit 3 is 1 and is 0 otherwise.
- R6: A write to offset 4 updates control bits 5 (xon_any_o) and 6 (ir_mode_o) only if the feature bit is 1. Otherwise these two bits keep their previous value.
- R7: Control bits 0 to 4 and bit 7 take the written value at the clock edge where we_i is sampled with offset 4. The outputs that follow these bits change at that same edge.
- R8: lb_ri_o equals control bit 2 while control bit 4 (loopback, loopback_o) is 1, and it is 0 otherwise.
- R9: A modem status read returns the four modem states in bits 7..4, with bits 3..0 at 0. The states are, in order, DCD (bit 7), RI (bit 6), DSR (bit 5) and CTS (bit 4). They come from modem_i[3:0] in that same order. In loopback they come instead from control bits 3, 2, 0 and 1.
- R10: rdata_o is loaded at the clock edge where re_i is sampled, and it holds between reads. Offsets 0, 1, 3 and 5 read 0x00.
- R11: Offset 2 holds the feature bit at bit position 4. A write loads it from wdata_i[4], and a read returns it in bit 4 with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| modem_i | input | 4 | Modem input states {DCD, RI, DSR, CTS}, 1 = asserted |
| irq_i | input | 1 | Interrupt request from the UART core |
| irq_o | output | 1 | Interrupt value towards the pin |
| irq_oe_o | output | 1 | Interrupt pin output enable (0 = high impedance) |
| gpo_n_o | output | 1 | General-purpose output, low when the interrupt is enabled |
| loopback_o | output | 1 | Internal loopback enable |
| xon_any_o | output | 1 | Xon-Any enable |
| ir_mode_o | output | 1 | Infrared mode enable |
| lb_ri_o | output | 1 | Ring-indicator value inside loopback |

## Verification
The assertions assume that the host never raises we_i and re_i in the same cycle. They also assume that addr_i and wdata_i are stable across the edge where a strobe is sampled. The bench drives strobes for exactly one cycle from the falling edge and never combines them. Random stimulus covers all eight offsets and arbitrary data, so the protected bits, the bank switch and the loopback mapping each see writes in both feature-bit states.

// File: rtl/uart_mcr_pkg.sv
package uart_mcr_pkg;
  localparam int unsigned AW = 3;
  localparam int unsigned DW = 8;

  localparam logic [AW-1:0] OFS_FEAT = 3'd2;
  localparam logic [AW-1:0] OFS_MCR  = 3'd4;
  localparam logic [AW-1:0] OFS_STAT = 3'd6;
  localparam logic [AW-1:0] OFS_LVL  = 3'd7;

  localparam int unsigned FEAT_BIT = 4;
  localparam int unsigned B_DTR = 0;
  localparam int unsigned B_RTS = 1;
  localparam int unsigned B_SEL = 2;
  localparam int unsigned B_IRQ = 3;
  localparam int unsigned B_LB  = 4;
  localparam int unsigned B_XON = 5;
  localparam int unsigned B_IR  = 6;

  localparam logic [DW-1:0] PROT_MASK = (DW'(1) << B_XON) | (DW'(1) << B_IR);

  typedef enum logic {BANK_STD = 1'b0, BANK_TRIG = 1'b1} bank_e;
endpackage

// File: rtl/uart_mcr_ctrl.sv
module uart_mcr_ctrl
  import uart_mcr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mcr_we_i,
  input  logic          feat_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] mcr_o,
  output logic          feat_o
);
  logic [DW-1:0] wmask;

  // protected bits pass only while the feature bit is set
  assign wmask = feat_o ? {DW{1'b1}} : ~PROT_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcr_o  <= '0;
      feat_o <= 1'b0;
    end else begin
      if (feat_we_i) feat_o <= wdata_i[FEAT_BIT];
      if (mcr_we_i)  mcr_o  <= (wdata_i & wmask) | (mcr_o & ~wmask);
    end
  end

  AST_PROT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mcr_we_i && !feat_o) |=> (mcr_o[B_IR:B_XON] == $past(mcr_o[B_IR:B_XON]))); // R6
endmodule

// File: rtl/uart_mcr_decode.sv
module uart_mcr_decode
  import uart_mcr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          feat_i,
  input  logic          sel_i,
  output logic          stat_hit_o,
  output logic          lvl_hit_o,
  output bank_e         bank_o
);
  assign stat_hit_o = (addr_i == OFS_STAT);
  assign lvl_hit_o  = (addr_i == OFS_LVL);
  assign bank_o     = (feat_i && sel_i) ? BANK_TRIG : BANK_STD;

  AST_STD_WITHOUT_FEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !feat_i |-> (bank_o == BANK_STD)); // R2
endmodule

// File: rtl/uart_mcr_aux.sv
module uart_mcr_aux
  import uart_mcr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          stat_hit_i,
  input  logic          lvl_hit_i,
  input  bank_e         bank_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] tcr_o,
  output logic [DW-1:0] tlr_o,
  output logic [DW-1:0] spr_o
);
  logic trig;
  assign trig = (bank_i == BANK_TRIG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tcr_o <= '0;
      tlr_o <= '0;
      spr_o <= '0;
    end else if (we_i) begin
      if (stat_hit_i && trig)  tcr_o <= wdata_i;
      if (lvl_hit_i && trig)   tlr_o <= wdata_i;
      if (lvl_hit_i && !trig)  spr_o <= wdata_i;
    end
  end

  AST_STATUS_READ_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && stat_hit_i && !trig) |=> ($stable(tcr_o) && $stable(tlr_o) && $stable(spr_o))); // R3
  AST_SPR_KEPT_IN_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && lvl_hit_i && trig) |=> $stable(spr_o)); // R4
endmodule

// File: rtl/uart_mcr_status.sv
module uart_mcr_status
  import uart_mcr_pkg::*;
#(
  parameter int unsigned NSIG = 4
) (
  input  logic [DW-1:0]   mcr_i,
  input  logic [NSIG-1:0] modem_i,
  output logic [DW-1:0]   msr_o
);
  localparam int unsigned LOW = DW - NSIG;

  logic [NSIG-1:0] lb_st;
  logic [NSIG-1:0] st;

  // loopback wiring: {DCD, RI, DSR, CTS} <- {bit3, bit2, bit0, bit1}
  assign lb_st = {mcr_i[B_IRQ], mcr_i[B_SEL], mcr_i[B_DTR], mcr_i[B_RTS]};

  for (genvar g = 0; g < NSIG; g++) begin : g_src
    assign st[g] = mcr_i[B_LB] ? lb_st[g] : modem_i[g];
  end

  assign msr_o = {st, {LOW{1'b0}}};
endmodule

// File: rtl/uart_mcr_bank.sv
module uart_mcr_bank
  import uart_mcr_pkg::*;
#(
  parameter int unsigned NSIG = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            we_i,
  input  logic            re_i,
  output logic [DW-1:0]   rdata_o,
  input  logic [NSIG-1:0] modem_i,
  input  logic            irq_i,
  output logic            irq_o,
  output logic            irq_oe_o,
  output logic            gpo_n_o,
  output logic            loopback_o,
  output logic            xon_any_o,
  output logic            ir_mode_o,
  output logic            lb_ri_o
);
  logic [DW-1:0] mcr, tcr, tlr, spr, msr, rd_mux;
  logic          feat, stat_hit, lvl_hit;
  bank_e         bank;

  uart_mcr_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .mcr_we_i  (we_i && addr_i == OFS_MCR),
    .feat_we_i (we_i && addr_i == OFS_FEAT),
    .wdata_i,
    .mcr_o     (mcr),
    .feat_o    (feat)
  );

  uart_mcr_decode u_dec (
    .clk_i, .rst_ni, .addr_i,
    .feat_i     (feat),
    .sel_i      (mcr[B_SEL]),
    .stat_hit_o (stat_hit),
    .lvl_hit_o  (lvl_hit),
    .bank_o     (bank)
  );

  uart_mcr_aux u_aux (
    .clk_i, .rst_ni, .we_i,
    .stat_hit_i (stat_hit),
    .lvl_hit_i  (lvl_hit),
    .bank_i     (bank),
    .wdata_i,
    .tcr_o      (tcr),
    .tlr_o      (tlr),
    .spr_o      (spr)
  );

  uart_mcr_status #(.NSIG(NSIG)) u_stat (
    .mcr_i   (mcr),
    .modem_i,
    .msr_o   (msr)
  );

  always_comb begin
    rd_mux = '0;
    if (addr_i == OFS_FEAT)     rd_mux = DW'(feat) << FEAT_BIT;
    else if (addr_i == OFS_MCR) rd_mux = mcr;
    else if (stat_hit)          rd_mux = (bank == BANK_TRIG) ? tcr : msr;
    else if (lvl_hit)           rd_mux = (bank == BANK_TRIG) ? tlr : spr;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= rd_mux;
  end

  assign irq_oe_o   = mcr[B_IRQ];
  assign irq_o      = irq_i & mcr[B_IRQ];
  assign gpo_n_o    = ~mcr[B_IRQ];
  assign loopback_o = mcr[B_LB];
  assign xon_any_o  = mcr[B_XON];
  assign ir_mode_o  = mcr[B_IR];
  assign lb_ri_o    = mcr[B_LB] & mcr[B_SEL];

  AST_IRQ_EN_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFS_MCR) |=> (irq_oe_o == $past(wdata_i[B_IRQ]))); // R7
  AST_GPO_OPPOSES_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gpo_n_o != irq_oe_o); // R5
  AST_RI_ONLY_IN_LOOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loopback_o |-> !lb_ri_o); // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && (addr_i == 3'd0 || addr_i == 3'd1 || addr_i == 3'd3 || addr_i == 3'd5))
      |=> (rdata_o == '0)); // R10
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o)); // R10
endmodule

// File: tb/uart_mcr_bank_bench.sv
module uart_mcr_bank_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       we = 1'b0, re = 1'b0;
  logic [7:0] rdata;
  logic [3:0] modem = '0;
  logic       irq_in = 1'b0;
  logic irq, irq_oe, gpo_n, lb, xon, ir, lb_ri;

  int total = 0;
  int bad = 0;

  logic [7:0] m_mcr, m_tcr, m_tlr, m_spr;
  logic       m_feat;

  always #2 clk = ~clk;

  uart_mcr_bank u_uart_mcr_bank (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata), .modem_i(modem),
    .irq_i(irq_in), .irq_o(irq), .irq_oe_o(irq_oe), .gpo_n_o(gpo_n),
    .loopback_o(lb), .xon_any_o(xon), .ir_mode_o(ir), .lb_ri_o(lb_ri)
  );

  function automatic logic trig_sel();
    return m_feat && m_mcr[2];
  endfunction

  function automatic logic [7:0] exp_msr();
    logic [3:0] s;
    s = m_mcr[4] ? {m_mcr[3], m_mcr[2], m_mcr[0], m_mcr[1]} : modem;
    return {s, 4'b0};
  endfunction

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd2:    return {3'b0, m_feat, 4'b0};
      3'd4:    return m_mcr;
      3'd6:    return trig_sel() ? m_tcr : exp_msr();
      3'd7:    return trig_sel() ? m_tlr : m_spr;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd2:    return "R11";
      3'd4:    return "R7";
      3'd6:    return trig_sel() ? "R2" : "R9";
      3'd7:    return "R4";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic model_wr(input logic [2:0] a, input logic [7:0] d);
    logic [7:0] mask;
    case (a)
      3'd2: m_feat = d[4];
      3'd4: begin
        mask  = m_feat ? 8'hFF : 8'h9F;
        m_mcr = (d & mask) | (m_mcr & ~mask);
      end
      3'd6: if (trig_sel()) m_tcr = d;
      3'd7: if (trig_sel()) m_tlr = d; else m_spr = d;
      default: ;
    endcase
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    model_wr(a, d);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    @(negedge clk);
    addr = a; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    check(tag, rdata, exp_rd(a));
  endtask

  task automatic check_pins();
    check("R5_oe",  {7'b0, irq_oe}, {7'b0, m_mcr[3]});
    check("R5_gpo", {7'b0, gpo_n},  {7'b0, ~m_mcr[3]});
    check("R5_irq", {7'b0, irq},    {7'b0, irq_in & m_mcr[3]});
    check("R7_lb",  {7'b0, lb},     {7'b0, m_mcr[4]});
    check("R6_xon", {7'b0, xon},    {7'b0, m_mcr[5]});
    check("R6_ir",  {7'b0, ir},     {7'b0, m_mcr[6]});
    check("R8_ri",  {7'b0, lb_ri},  {7'b0, m_mcr[4] & m_mcr[2]});
  endtask

  initial begin
    #(4 * 150000);
    bad++; total++;
    $display("FAIL watchdog got=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    m_mcr = '0; m_tcr = '0; m_tlr = '0; m_spr = '0; m_feat = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1_gpo", {7'b0, gpo_n}, 8'h01);
    check("R1_oe",  {7'b0, irq_oe}, 8'h00);
    check("R1_ctl", {4'b0, lb, xon, ir, lb_ri}, 8'h00);
    rd(3'd4, "R1");
    rd(3'd2, "R1");
    rd(3'd7, "R1");
    wr(3'd2, 8'h10); wr(3'd4, 8'h04);
    rd(3'd6, "R1"); rd(3'd7, "R1");
    wr(3'd4, 8'h00); wr(3'd2, 8'h00);

    // R6 protected bits without feature bit
    wr(3'd4, 8'hFF);
    rd(3'd4, "R6"); check_pins();
    irq_in = 1'b1; #0; check_pins(); irq_in = 1'b0;
    wr(3'd2, 8'h10);
    wr(3'd4, 8'h60);
    rd(3'd4, "R6"); check_pins();
    wr(3'd2, 8'hEF);
    rd(3'd2, "R11");
    wr(3'd4, 8'h00);
    rd(3'd4, "R6");

    // R2/R4 banked storage
    wr(3'd2, 8'h10);
    wr(3'd4, 8'h04);
    wr(3'd6, 8'hA5); wr(3'd7, 8'h5A);
    rd(3'd6, "R2"); rd(3'd7, "R4");
    wr(3'd4, 8'h00);
    modem = 4'b1010;
    rd(3'd6, "R9"); rd(3'd7, "R4");
    // R3 status write ignored
    wr(3'd6, 8'h33);
    rd(3'd6, "R3");
    wr(3'd4, 8'h04);
    rd(3'd6, "R3");
    // R2 feature off overrides select bit
    wr(3'd2, 8'h00);
    rd(3'd6, "R2"); rd(3'd7, "R2");

    // R8/R9 loopback
    wr(3'd4, 8'h1F);
    check_pins();
    rd(3'd6, "R9");
    wr(3'd4, 8'h12);
    check_pins();
    rd(3'd6, "R9");
    wr(3'd4, 8'h0F);
    rd(3'd6, "R9"); check_pins();

    // R10 unmapped and hold
    rd(3'd0, "R10"); rd(3'd3, "R10"); rd(3'd5, "R10");
    rd(3'd7, "R10");
    @(negedge clk); addr = 3'd4;
    @(negedge clk); check("R10_hold", rdata, exp_rd(3'd7));

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [2:0] a;
      int op;
      a = 3'($urandom_range(0, 7));
      op = $urandom_range(0, 9);
      if (op < 4) begin
        wr(a, 8'($urandom));
        check_pins();
      end else if (op < 9) begin
        rd(a, tag_of(a));
      end else begin
        modem = 4'($urandom);
        irq_in = 1'($urandom);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule